// File: doc/BRIEF.md
# Instruction Cycle Cost Meter

This block prices a stream of decoded integer instructions in clock cycles. Each beat on which `inValid` is high carries one instruction descriptor: a class code, a destination register, two source registers, and flags for branch taken, delay-slot annulled, delay slot useful and trap. For every accepted descriptor the block reports that instruction's cycle cost one clock later, and it adds that cost to a saturating running total.

The cost model covers the integer pipeline only. It applies a fixed latency per class, penalties for control transfers and traps, and a one-cycle load-use interlock. The interlock compares the current instruction's sources against the destination of the load accepted immediately before it. A static `coreVariant` input selects between two pipeline flavours. They differ in the cost of untaken branches and in whether a load into register zero interlocks.

Top module: `cycle_cost_meter`

## Requirements
- R1: Class codes on `inClass`: 0 plain ALU = 1 cycle, 1 single-word load = 2, 2 doubleword load = 3, 3 single-word store = 3, 4 doubleword store = 4, 5 atomic load-store byte = 4, 6 swap = 4. Codes 11 to 15 cost 1 cycle and are not control transfers.
- R2: Class 9 (register-indirect jump) and class 10 (trap return) each cost 2 cycles. Class 8 (direct call) costs 1 cycle.
- R3: Class 7 (branch) costs 1 cycle, except when `coreVariant` is 0 and `inTaken` is 0, in which case it costs 2. With `coreVariant` 1 an untaken branch costs 1.
- R4: A branch with `inAnnul` set costs 1 cycle more. `inAnnul` has no effect on any other class.
- R5: Classes 7, 8, 9 and 10 with `inSlotUseful` low cost 1 cycle more. `inSlotUseful` has no effect on other classes.
- R6: `inTrap` set adds 3 cycles to any instruction.
- R7: If the previously accepted instruction was a single-word load with destination d, and the current instruction has `inSrcA` or `inSrcB` equal to d, the current instruction costs 1 cycle more.
- R8: After a doubleword load with destination d, the stall of R7 applies only when a source equals the odd register of the pair (d with bit 0 forced to 1). A source equal to the even register does not stall.
- R9: With `coreVariant` 1, a single-word load into register 0 followed by a read of register 0 causes no stall. With `coreVariant` 0 it does stall.
- R10: Only the immediately preceding accepted instruction can cause a stall. Idle beats in between do not break the pairing. A trap instruction, synchronous reset, or any non-load instruction clears the remembered load.
- R11: `costValid` is high and `costOut` holds the cost in the clock after an accepted beat. On every other clock `costValid` is low.
- R12: `totalOut` (TOTAL_W bits, 32 by default) is cleared by synchronous reset. It grows by each reported cost in the same clock that `costOut` shows it, saturates at all ones, and is unchanged after an idle beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coreVariant | input | 1 | 0 selects variant A, 1 selects variant B |
| inValid | input | 1 | Descriptor present on this beat |
| inClass | input | 4 | Instruction class code |
| inDest | input | REG_W | Destination register number |
| inSrcA | input | REG_W | First source register number |
| inSrcB | input | REG_W | Second source register number |
| inTaken | input | 1 | Branch taken |
| inAnnul | input | 1 | Branch annuls its delay slot |
| inSlotUseful | input | 1 | Delay slot holds a useful instruction |
| inTrap | input | 1 | Instruction traps |
| costValid | output | 1 | A cost is reported this clock |
| costOut | output | COST_W | Cycle cost of the last accepted instruction |
| totalOut | output | TOTAL_W | Saturating running cycle total |

## Verification
The only hidden state is the remembered load destination and its armed bit. If either is wrong, the error shows on `costOut` in the clock after the very next accepted instruction, as a missing or spurious extra cycle. The same error shows on `totalOut` in that same clock. The bench therefore pairs each load form with a dependent and an independent successor, and it also separates pairs with idle beats, traps and reset. A wrong total register shows on the first report after an accept, or on any idle beat, and the saturation case drives it to the top of a narrowed counter.

// File: rtl/cycle_cost_pkg.sv
package cycle_cost_pkg;

  typedef enum logic [3:0] {
    CLS_ALU    = 4'd0,
    CLS_LD     = 4'd1,
    CLS_LDD    = 4'd2,
    CLS_ST     = 4'd3,
    CLS_STD    = 4'd4,
    CLS_LDSTUB = 4'd5,
    CLS_SWAP   = 4'd6,
    CLS_BR     = 4'd7,
    CLS_CALL   = 4'd8,
    CLS_JMPL   = 4'd9,
    CLS_RETT   = 4'd10
  } instClass_e;

  // Strobes handed from control to datapath for one accepted beat.
  typedef struct packed {
    logic       accept;
    logic [2:0] baseCost;
    logic       branchExtra;
    logic       annulExtra;
    logic       slotExtra;
    logic       trapExtra;
    logic       stallExtra;
  } costStrobes_t;

endpackage

// File: rtl/cycle_cost_ctrl.sv
module cycle_cost_ctrl
  import cycle_cost_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coreVariant,
  input  logic             inValid,
  input  logic [3:0]       inClass,
  input  logic [REG_W-1:0] inDest,
  input  logic [REG_W-1:0] inSrcA,
  input  logic [REG_W-1:0] inSrcB,
  input  logic             inTaken,
  input  logic             inAnnul,
  input  logic             inSlotUseful,
  input  logic             inTrap,
  output costStrobes_t     strobes
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic             hazArmed;
  logic [REG_W-1:0] hazReg;
  logic             isBranch;
  logic             isTransfer;
  logic             srcHit;
  logic             zeroExempt;

  // Base latency per class and control-transfer decode.
  always_comb begin
    strobes.baseCost = 3'd1;
    isBranch   = 1'b0;
    isTransfer = 1'b0;
    case (inClass)
      CLS_LD:                     strobes.baseCost = 3'd2;
      CLS_LDD, CLS_ST:            strobes.baseCost = 3'd3;
      CLS_STD, CLS_LDSTUB,
      CLS_SWAP:                   strobes.baseCost = 3'd4;
      CLS_BR: begin
        isBranch   = 1'b1;
        isTransfer = 1'b1;
      end
      CLS_CALL:                   isTransfer = 1'b1;
      CLS_JMPL, CLS_RETT: begin
        strobes.baseCost = 3'd2;
        isTransfer       = 1'b1;
      end
      default:                    strobes.baseCost = 3'd1;
    endcase
  end

  // Load-use interlock against the single remembered destination.
  always_comb begin
    srcHit     = (inSrcA == hazReg) || (inSrcB == hazReg);
    zeroExempt = coreVariant && (hazReg == ZERO_REG);
  end

  always_comb begin
    strobes.accept      = inValid;
    strobes.branchExtra = isBranch && !coreVariant && !inTaken;
    strobes.annulExtra  = isBranch && inAnnul;
    strobes.slotExtra   = isTransfer && !inSlotUseful;
    strobes.trapExtra   = inTrap;
    strobes.stallExtra  = hazArmed && srcHit && !zeroExempt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hazArmed <= 1'b0;
      hazReg   <= '0;
    end else if (inValid) begin
      if (inTrap) begin
        hazArmed <= 1'b0;
      end else if (inClass == CLS_LD) begin
        hazArmed <= 1'b1;
        hazReg   <= inDest;
      end else if (inClass == CLS_LDD) begin
        hazArmed <= 1'b1;
        hazReg   <= {inDest[REG_W-1:1], 1'b1};
      end else begin
        hazArmed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cycle_cost_datapath.sv
module cycle_cost_datapath
  import cycle_cost_pkg::*;
#(
  parameter int COST_W  = 4,
  parameter int TOTAL_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  costStrobes_t       strobes,
  output logic               costValid,
  output logic [COST_W-1:0]  costOut,
  output logic [TOTAL_W-1:0] totalOut
);

  localparam logic [TOTAL_W-1:0] TOTAL_MAX = {TOTAL_W{1'b1}};

  logic [COST_W-1:0]  costNext;
  logic [TOTAL_W:0]   wideSum;

  always_comb begin
    costNext = COST_W'(strobes.baseCost)
             + COST_W'(strobes.branchExtra)
             + COST_W'(strobes.annulExtra)
             + COST_W'(strobes.slotExtra)
             + COST_W'(strobes.stallExtra)
             + (strobes.trapExtra ? COST_W'(3) : '0);
    wideSum  = {1'b0, totalOut} + (TOTAL_W + 1)'(costNext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      costValid <= 1'b0;
      costOut   <= '0;
      totalOut  <= '0;
    end else begin
      costValid <= strobes.accept;
      if (strobes.accept) begin
        costOut  <= costNext;
        totalOut <= wideSum[TOTAL_W] ? TOTAL_MAX : wideSum[TOTAL_W-1:0];
      end
    end
  end

endmodule

// File: rtl/cycle_cost_meter.sv
module cycle_cost_meter
  import cycle_cost_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int COST_W  = 4,
  parameter int TOTAL_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               coreVariant,
  input  logic               inValid,
  input  logic [3:0]         inClass,
  input  logic [REG_W-1:0]   inDest,
  input  logic [REG_W-1:0]   inSrcA,
  input  logic [REG_W-1:0]   inSrcB,
  input  logic               inTaken,
  input  logic               inAnnul,
  input  logic               inSlotUseful,
  input  logic               inTrap,
  output logic               costValid,
  output logic [COST_W-1:0]  costOut,
  output logic [TOTAL_W-1:0] totalOut
);

  costStrobes_t strobes;

  cycle_cost_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .coreVariant  (coreVariant),
    .inValid      (inValid),
    .inClass      (inClass),
    .inDest       (inDest),
    .inSrcA       (inSrcA),
    .inSrcB       (inSrcB),
    .inTaken      (inTaken),
    .inAnnul      (inAnnul),
    .inSlotUseful (inSlotUseful),
    .inTrap       (inTrap),
    .strobes      (strobes)
  );

  cycle_cost_datapath #(.COST_W(COST_W), .TOTAL_W(TOTAL_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .costValid (costValid),
    .costOut   (costOut),
    .totalOut  (totalOut)
  );

endmodule

// File: rtl/cycle_cost_meter_chk.sv
module cycle_cost_meter_chk #(
  parameter int COST_W  = 4,
  parameter int TOTAL_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [3:0]         inClass,
  input logic               inTrap,
  input logic               costValid,
  input logic [COST_W-1:0]  costOut,
  input logic [TOTAL_W-1:0] totalOut
);

  // R11
  valid_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    costValid |-> $past(inValid));

  // R1
  cost_range_chk: assert property (@(posedge clk) disable iff (rst)
    costValid |-> (costOut >= COST_W'(1)) && (costOut <= COST_W'(8)));

  // R6
  trap_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (costValid && $past(inTrap)) |-> (costOut >= COST_W'(4)));

  // R1
  alu_cost_chk: assert property (@(posedge clk) disable iff (rst)
    (costValid && $past(inClass) == 4'd0 && !$past(inTrap)) |-> (costOut <= COST_W'(2)));

  // R12
  total_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (totalOut >= $past(totalOut)));

  // R12
  idle_total_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(inValid)) |-> $stable(totalOut));

endmodule

bind cycle_cost_meter cycle_cost_meter_chk #(.COST_W(COST_W), .TOTAL_W(TOTAL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inClass   (inClass),
  .inTrap    (inTrap),
  .costValid (costValid),
  .costOut   (costOut),
  .totalOut  (totalOut)
);

// File: tb/sim_cycle_cost_meter.sv
`timescale 1ns/1ps
module sim_cycle_cost_meter;
  import cycle_cost_pkg::*;

  localparam int REG_W   = 5;
  localparam int COST_W  = 4;
  localparam int TOTAL_W = 10;
  localparam longint TMAX = (64'd1 << TOTAL_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coreVariant = 1'b0;
  logic inValid = 1'b0;
  logic [3:0] inClass = '0;
  logic [REG_W-1:0] inDest = '0, inSrcA = '0, inSrcB = '0;
  logic inTaken = 1'b0, inAnnul = 1'b0, inSlotUseful = 1'b1, inTrap = 1'b0;
  logic costValid;
  logic [COST_W-1:0] costOut;
  logic [TOTAL_W-1:0] totalOut;

  int checks = 0;
  int fails = 0;
  longint expTotal = 0;

  always #4 clk = ~clk;

  cycle_cost_meter #(.REG_W(REG_W), .COST_W(COST_W), .TOTAL_W(TOTAL_W)) u0 (
    .clk(clk), .rst(rst), .coreVariant(coreVariant), .inValid(inValid),
    .inClass(inClass), .inDest(inDest), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .inTaken(inTaken), .inAnnul(inAnnul), .inSlotUseful(inSlotUseful),
    .inTrap(inTrap), .costValid(costValid), .costOut(costOut), .totalOut(totalOut)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one descriptor, then check the report in the following clock.
  task automatic issue(input logic [3:0] cls, input int dst, input int sa, input int sb,
                       input logic tk, input logic an, input logic us, input logic tr,
                       input int expCost, input string tag);
    inValid = 1'b1; inClass = cls;
    inDest = REG_W'(dst); inSrcA = REG_W'(sa); inSrcB = REG_W'(sb);
    inTaken = tk; inAnnul = an; inSlotUseful = us; inTrap = tr;
    @(negedge clk);
    inValid = 1'b0;
    expTotal = expTotal + expCost;
    if (expTotal > TMAX) expTotal = TMAX;
    chk({tag, " R11 valid"}, costValid, 1);
    chk({tag, " cost"}, costOut, expCost);
    chk({tag, " R12 total"}, totalOut, expTotal);
  endtask

  task automatic plain(input logic [3:0] cls, input int dst, input int sa, input int sb,
                       input int expCost, input string tag);
    issue(cls, dst, sa, sb, 1'b1, 1'b0, 1'b1, 1'b0, expCost, tag);
  endtask

  task automatic idle(input string tag);
    inValid = 1'b0;
    @(negedge clk);
    chk({tag, " R11 idle valid"}, costValid, 0);
    chk({tag, " R12 idle total"}, totalOut, expTotal);
  endtask

  task automatic doReset();
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    expTotal = 0;
    chk("R12 reset total", totalOut, 0);
    chk("R11 reset valid", costValid, 0);
  endtask

  task automatic testLatencies();
    coreVariant = 1'b0;
    plain(CLS_ALU, 1, 2, 3, 1, "R1 alu");
    plain(CLS_LD, 5, 2, 3, 2, "R1 ld");
    plain(CLS_LDD, 10, 1, 2, 3, "R1 ldd");
    plain(CLS_ST, 4, 1, 2, 3, "R1 st");
    plain(CLS_STD, 4, 1, 2, 4, "R1 std");
    plain(CLS_LDSTUB, 4, 1, 2, 4, "R1 ldstub");
    plain(CLS_SWAP, 4, 1, 2, 4, "R1 swap");
    plain(4'd13, 4, 1, 2, 1, "R1 unused code");
    plain(CLS_CALL, 15, 1, 2, 1, "R2 call");
    plain(CLS_JMPL, 15, 1, 2, 2, "R2 jmpl");
    plain(CLS_RETT, 15, 1, 2, 2, "R2 rett");
  endtask

  task automatic testBranches();
    coreVariant = 1'b0;
    issue(CLS_BR, 0, 1, 2, 1, 0, 1, 0, 1, "R3 A taken");
    issue(CLS_BR, 0, 1, 2, 0, 0, 1, 0, 2, "R3 A untaken");
    issue(CLS_BR, 0, 1, 2, 1, 1, 1, 0, 2, "R4 annul");
    issue(CLS_BR, 0, 1, 2, 1, 0, 0, 0, 2, "R5 br empty slot");
    issue(CLS_BR, 0, 1, 2, 0, 1, 0, 0, 4, "R3 R4 R5 A combined");
    issue(CLS_ALU, 0, 1, 2, 1, 1, 0, 0, 1, "R4 R5 alu flags ignored");
    issue(CLS_CALL, 0, 1, 2, 1, 0, 0, 0, 2, "R5 call empty");
    issue(CLS_JMPL, 0, 1, 2, 1, 0, 0, 0, 3, "R5 jmpl empty");
    issue(CLS_RETT, 0, 1, 2, 1, 1, 0, 0, 3, "R4 R5 rett annul ignored");
    coreVariant = 1'b1;
    issue(CLS_BR, 0, 1, 2, 0, 0, 1, 0, 1, "R3 B untaken");
    issue(CLS_BR, 0, 1, 2, 0, 1, 0, 0, 3, "R3 B combined");
    coreVariant = 1'b0;
  endtask

  task automatic testTraps();
    issue(CLS_ALU, 0, 1, 2, 1, 0, 1, 1, 4, "R6 alu trap");
    issue(CLS_BR, 0, 1, 2, 0, 1, 0, 1, 7, "R6 branch trap");
  endtask

  task automatic testLoadUse();
    coreVariant = 1'b0;
    plain(CLS_LD, 7, 1, 2, 2, "R7 ld");
    plain(CLS_ALU, 3, 7, 2, 2, "R7 srcA stall");
    plain(CLS_LD, 7, 1, 2, 2, "R7 ld");
    plain(CLS_ST, 3, 1, 7, 4, "R7 srcB stall on store");
    plain(CLS_LD, 7, 1, 2, 2, "R7 ld");
    plain(CLS_ALU, 3, 1, 2, 1, "R7 independent");
    plain(CLS_ALU, 3, 7, 2, 1, "R10 two back no stall");
    plain(CLS_LD, 7, 1, 2, 2, "R10 ld");
    idle("R10");
    plain(CLS_ALU, 3, 7, 2, 2, "R10 stall across idle");
    plain(CLS_LDD, 8, 1, 2, 3, "R8 ldd");
    plain(CLS_ALU, 3, 8, 8, 1, "R8 even reg no stall");
    plain(CLS_LDD, 8, 1, 2, 3, "R8 ldd");
    plain(CLS_ALU, 3, 1, 9, 2, "R8 odd reg stall");
  endtask

  task automatic testZeroReg();
    coreVariant = 1'b0;
    plain(CLS_LD, 0, 1, 2, 2, "R9 A ld r0");
    plain(CLS_ALU, 3, 0, 0, 2, "R9 A r0 stalls");
    coreVariant = 1'b1;
    plain(CLS_LD, 0, 1, 2, 2, "R9 B ld r0");
    plain(CLS_ALU, 3, 0, 0, 1, "R9 B r0 exempt");
    plain(CLS_LD, 6, 1, 2, 2, "R9 B ld r6");
    plain(CLS_ALU, 3, 6, 0, 2, "R9 B nonzero stalls");
    coreVariant = 1'b0;
  endtask

  task automatic testClears();
    issue(CLS_LD, 7, 1, 2, 1, 0, 1, 1, 5, "R10 trapped ld");
    plain(CLS_ALU, 3, 7, 2, 1, "R10 trap clears");
    plain(CLS_LD, 7, 1, 2, 2, "R10 ld");
    issue(CLS_ALU, 3, 7, 2, 1, 0, 1, 1, 5, "R10 trap reader stalls");
    plain(CLS_ALU, 3, 7, 2, 1, "R10 after trap");
    plain(CLS_LD, 7, 1, 2, 2, "R10 ld before reset");
    doReset();
    plain(CLS_ALU, 3, 7, 2, 1, "R10 reset clears");
  endtask

  task automatic testSaturation();
    for (int i = 0; i < 150; i++) begin
      issue(CLS_STD, 0, 1, 2, 1, 0, 1, 1, 7, "R12 saturate");
    end
    chk("R12 held at max", totalOut, TMAX);
    idle("R12 saturated");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset total", totalOut, 0);
    chk("R11 reset valid", costValid, 0);
    chk("R11 reset cost", costOut, 0);
    rst = 1'b0;
    idle("R11 first");
    testLatencies();
    testBranches();
    testTraps();
    testLoadUse();
    testZeroReg();
    testClears();
    testSaturation();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule